// File: doc/BRIEF.md
# Adaptive Ternary Data Slicer

The slicer turns signed amplitude samples of a bipolar (three-level) line signal into two mark bits, one for positive pulses and one for negative pulses. It does not use a fixed decision level. It derives the level from a peak-amplitude reference supplied by an upstream peak detector. A two-bit select field scales that reference to 40%, 50%, 60% or 70%.

A sample whose value lies strictly above the scaled level produces a positive mark. A sample strictly below the negated level produces a negative mark. Any other sample is a space.

The decision is registered and appears one clock after the sample strobe. It is steered to one of two destinations, chosen by a recovery-enable input that is taken in the same cycle as the sample:
- With recovery disabled, the decision goes to the plain positive and negative output rails.
- With recovery enabled, the decision goes to the port group that feeds a downstream clock recovery stage.

The unused group is held at zero.

Top module: `tern_slicer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first sample strobe, every output is 0.
- R2: The decision level is floor(peak × pct / 100). `pct` is 40 for `lvl_sel`=2'b00, 50 for 2'b01, 60 for 2'b10 and 70 for 2'b11.
- R3: A strobed sample strictly greater than the decision level gives a positive mark (P=1, N=0).
- R4: A strobed sample strictly less than the negated decision level gives a negative mark (P=0, N=1).
- R5: A sample equal to +level or -level, or lying between them, gives a space (P=0, N=0). This includes a sample of 0 when the level is 0.
- R6: The positive and negative bits of a group are never both 1.
- R7: The decision for a sample strobed at clock edge k appears, with its group's valid bit high, after edge k and holds until edge k+1.
- R8: When `rec_en` is 0 at the strobe, the decision appears on `rail_p`/`rail_n` with `rail_vld`=1. In that cycle `rec_p`, `rec_n` and `rec_vld` are 0.
- R9: When `rec_en` is 1 at the strobe, the decision appears on `rec_p`/`rec_n` with `rec_vld`=1. In that cycle `rail_p`, `rail_n` and `rail_vld` are 0.
- R10: In a cycle without a strobe, both valid bits fall to 0. The mark bits keep their previous values, whatever the sample, peak or select inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | SW | Signed amplitude sample |
| peak | input | SW-1 | Unsigned peak amplitude reference |
| lvl_sel | input | 2 | Threshold percentage select |
| rec_en | input | 1 | Route decisions to the clock recovery group |
| rail_p | output | 1 | Positive mark, direct rail |
| rail_n | output | 1 | Negative mark, direct rail |
| rail_vld | output | 1 | Direct rail decision valid |
| rec_p | output | 1 | Positive mark to clock recovery |
| rec_n | output | 1 | Negative mark to clock recovery |
| rec_vld | output | 1 | Clock recovery decision valid |

## Verification
Every result of this block is due exactly one clock after the strobe that carries its sample, peak, select and routing value. Each scenario task drives its inputs on a falling edge and drops the strobe on the next falling edge. It then compares all six outputs at that point, half a cycle after the capturing rising edge and before the next one.

The hold behaviour is checked by leaving the strobe low for several cycles while the sample and select inputs move to values that would flip the decision. The outputs are re-read on each of those cycles.

// File: rtl/tern_slicer.sv
module tern_slicer #(
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] smp,
  input  logic        [SW-2:0] peak,
  input  logic        [1:0]    lvl_sel,
  input  logic                 rec_en,
  output logic                 rail_p,
  output logic                 rail_n,
  output logic                 rail_vld,
  output logic                 rec_p,
  output logic                 rec_n,
  output logic                 rec_vld
);
  localparam int PW = SW - 1;
  localparam int MW = PW + 7;

  logic [MW-1:0]        scaled;
  logic [MW-1:0]        lvl_wide;
  logic signed [SW-1:0] lvl;
  logic                 dp, dn;

  always_comb begin
    case (lvl_sel)
      2'b00:   scaled = (MW'(peak) << 5) + (MW'(peak) << 3);
      2'b01:   scaled = (MW'(peak) << 5) + (MW'(peak) << 4) + (MW'(peak) << 1);
      2'b10:   scaled = (MW'(peak) << 5) + (MW'(peak) << 4) + (MW'(peak) << 3) + (MW'(peak) << 2);
      default: scaled = (MW'(peak) << 6) + (MW'(peak) << 2) + (MW'(peak) << 1);
    endcase
  end

  assign lvl_wide = scaled / MW'(100);
  assign lvl      = $signed({1'b0, lvl_wide[PW-1:0]});
  assign dp       = smp > lvl;
  assign dn       = smp < -lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_p <= 1'b0; rail_n <= 1'b0; rail_vld <= 1'b0;
      rec_p  <= 1'b0; rec_n  <= 1'b0; rec_vld  <= 1'b0;
    end else begin
      rail_vld <= smp_vld && !rec_en;
      rec_vld  <= smp_vld && rec_en;
      if (smp_vld) begin
        rail_p <= dp && !rec_en;
        rail_n <= dn && !rec_en;
        rec_p  <= dp && rec_en;
        rec_n  <= dn && rec_en;
      end
    end
  end
endmodule

module tern_slicer_chk #(
  parameter int SW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_vld,
  input logic signed [SW-1:0] smp,
  input logic                 rec_en,
  input logic                 rail_p,
  input logic                 rail_n,
  input logic                 rail_vld,
  input logic                 rec_p,
  input logic                 rec_n,
  input logic                 rec_vld
);
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(rail_p && rail_n) && !(rec_p && rec_n)); // R6
  AST_STROBE_LAT: assert property (@(posedge clk) disable iff (!rst_n) smp_vld |=> (rail_vld || rec_vld)); // R7
  AST_RAIL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && !rec_en) |=> (rail_vld && !rec_vld && !rec_p && !rec_n)); // R8
  AST_REC_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && rec_en) |=> (rec_vld && !rail_vld && !rail_p && !rail_n)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> (!rail_vld && !rec_vld && $stable(rail_p) && $stable(rail_n) && $stable(rec_p) && $stable(rec_n))); // R10
  AST_ZERO_SPACE: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && smp == '0) |=> (!rail_p && !rail_n && !rec_p && !rec_n)); // R5
endmodule

bind tern_slicer tern_slicer_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .rec_en(rec_en),
  .rail_p(rail_p), .rail_n(rail_n), .rail_vld(rail_vld),
  .rec_p(rec_p), .rec_n(rec_n), .rec_vld(rec_vld)
);

// File: tb/tern_slicer_tb.sv
module tern_slicer_tb;
  localparam int SW = 12;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 smp_vld = 1'b0;
  logic signed [SW-1:0] smp = '0;
  logic        [SW-2:0] peak = '0;
  logic        [1:0]    lvl_sel = 2'b00;
  logic                 rec_en = 1'b0;
  logic rail_p, rail_n, rail_vld, rec_p, rec_n, rec_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tern_slicer #(.SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .peak(peak),
    .lvl_sel(lvl_sel), .rec_en(rec_en), .rail_p(rail_p), .rail_n(rail_n),
    .rail_vld(rail_vld), .rec_p(rec_p), .rec_n(rec_n), .rec_vld(rec_vld)
  );

  function automatic int level(int pk, int sel);
    int pct;
    pct = (sel == 0) ? 40 : (sel == 1) ? 50 : (sel == 2) ? 60 : 70;
    return (pk * pct) / 100;
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {rail_p,rail_n,rail_vld,rec_p,rec_n,rec_vld} = %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {rail_p, rail_n, rail_vld, rec_p, rec_n, rec_vld};
  endfunction

  task automatic slice(string req, int s, int pk, int sel, bit ren);
    int t;
    logic p, n;
    @(negedge clk);
    smp = SW'(s); peak = (SW-1)'(pk); lvl_sel = 2'(sel); rec_en = ren; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    t = level(pk, sel);
    p = (s > t);
    n = (s < -t);
    check(req, outs(), ren ? {3'b000, p, n, 1'b1} : {p, n, 1'b1, 3'b000});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in reset", outs(), 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", outs(), 6'b0);
  endtask

  task automatic t_levels();
    for (int sel = 0; sel < 4; sel++) begin
      int t;
      t = level(1000, sel);
      slice("R3 R2 just above", t + 1, 1000, sel, 1'b0);
      slice("R5 R2 equal +lvl", t, 1000, sel, 1'b0);
      slice("R5 equal -lvl", -t, 1000, sel, 1'b0);
      slice("R4 R2 just below", -t - 1, 1000, sel, 1'b0);
    end
  endtask

  task automatic t_trunc();
    slice("R2 trunc 70% of 999 (699): 700 mark", 700, 999, 3, 1'b0);
    slice("R2 trunc 70% of 999: 699 space", 699, 999, 3, 1'b0);
    slice("R2 trunc 40% of 7 (2): 3 mark", 3, 7, 0, 1'b0);
    slice("R2 trunc 40% of 7: -2 space", -2, 7, 0, 1'b0);
    slice("R2 trunc 60% of 2047 (1228): -1229 mark", -1229, 2047, 2, 1'b0);
    slice("R5 zero level, zero sample", 0, 0, 1, 1'b0);
    slice("R3 zero level, +1", 1, 0, 1, 1'b0);
    slice("R4 zero level, -1", -1, 0, 1, 1'b0);
    slice("R3 full scale", 2047, 2047, 3, 1'b0);
    slice("R4 most negative", -2048, 2047, 3, 1'b0);
  endtask

  task automatic t_route();
    slice("R9 rec positive", 600, 1000, 1, 1'b1);
    slice("R9 rec negative", -600, 1000, 1, 1'b1);
    slice("R9 rec space", 100, 1000, 1, 1'b1);
    slice("R8 back to rail negative", -800, 1000, 2, 1'b0);
  endtask

  task automatic t_hold();
    slice("R8 rail positive before idle", 900, 1000, 0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      smp = SW'(-1500 + k); lvl_sel = 2'(k); rec_en = k[0]; peak = 11'(k);
      @(negedge clk);
      check("R10 idle hold", outs(), 6'b100000);
    end
    slice("R7 strobe after idle", -900, 1000, 0, 1'b1);
    @(negedge clk);
    check("R10 rec hold", outs(), 6'b000010);
  endtask

  initial begin
    t_reset();
    t_levels();
    t_trunc();
    t_route();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule